// File: doc/BRIEF.md
# Register-File and ALU Execute Datapath

This block is the execute and write-back half of a single-cycle 32-bit load/store processor. It holds a 32-entry by 32-bit register file with two combinational read ports and one clocked write port, an immediate widener that turns a 16-bit field into a 32-bit operand, a three-function ALU with an all-zero flag, and the multiplexers that route operands and write-back data between them.

An external decoder supplies the register indices taken from the instruction word, the 16-bit immediate and a handful of single-bit steering controls plus a 3-bit ALU function code. The ALU result leaves the block as the data-memory address, the second register read port leaves as the store data, and the zero flag goes back to the fetch logic for branch decisions. Data returned by the memory comes in on a separate bus and may be written back to a register at the clock edge.

Top module: `rf_alu_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register is cleared, so after reset any index reads 0 on `st_data`.
- R2: Register index 0 always reads as zero on both read ports, and a write addressed to it has no effect.
- R3: A register is updated only at a rising clock edge with `ctl_wr_en` = 1; with `ctl_wr_en` = 0 the register contents are unchanged. Reads are combinational, so a written value is visible right after the edge.
- R4: The write index is `rt_idx` when `ctl_dst_rd` = 0 and `rd_idx` when `ctl_dst_rd` = 1; the other register is left unchanged.
- R5: The ALU second operand is the register read through `rt_idx` when `ctl_use_imm` = 0, and the widened immediate when `ctl_use_imm` = 1. The first operand is always the register read through `rs_idx`.
- R6: With `ctl_sext` = 0 the immediate is zero-extended to 32 bits; with `ctl_sext` = 1 bit 15 of `imm_in` is copied into bits 31..16.
- R7: The value written back is the ALU result when `ctl_load` = 0 and `ld_data` when `ctl_load` = 1.
- R8: `ctl_alu_op` codes: 3'b000 add (modulo 2^32), 3'b001 subtract first minus second operand (modulo 2^32), 3'b010 bitwise OR; codes 3'b011 to 3'b111 produce a result of 0.
- R9: `alu_zero` is 1 exactly when the ALU result is all zeros, so subtracting equal registers raises it.
- R10: `mem_addr` carries the ALU result and `st_data` always carries the register read through `rt_idx`, whatever the other controls are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| rs_idx | input | 5 | Index of the register feeding the ALU first operand |
| rt_idx | input | 5 | Index of the second read register; also a write-index choice |
| rd_idx | input | 5 | Alternative write index |
| imm_in | input | 16 | Immediate field to be widened |
| ctl_wr_en | input | 1 | Enables the register write at the next edge |
| ctl_dst_rd | input | 1 | 0: write to rt_idx, 1: write to rd_idx |
| ctl_use_imm | input | 1 | 0: second operand from register, 1: from immediate |
| ctl_sext | input | 1 | 0: zero-extend immediate, 1: sign-extend |
| ctl_load | input | 1 | 0: write back ALU result, 1: write back ld_data |
| ctl_alu_op | input | 3 | ALU function code |
| ld_data | input | 32 | Read data returned by data memory |
| mem_addr | output | 32 | ALU result, used as data-memory address |
| st_data | output | 32 | Register read through rt_idx, used as store data |
| alu_zero | output | 1 | High when the ALU result is zero |

## Verification
The properties take for granted that every control input and index is a known value from the first edge after reset and that the decoder holds them steady across a whole clock period, since a write is committed from whatever is present at the edge. The write-back properties also assume that when a load lands in a register, the same `rt_idx` may or may not be held into the next cycle, and only judge the case where it is. The directed stimulus changes all inputs only on the falling edge, keeps indices within the 32 legal entries, and returns every control to an idle, non-writing setting between scenarios.

// File: rtl/rf_alu_pkg.sv
// Package rf_alu_pkg
// Shared encodings for the execute datapath. Assumes a 3-bit ALU
// function field driven by an external decoder.
package rf_alu_pkg;

    localparam int ALU_OP_W = 3;

    typedef enum logic [ALU_OP_W-1:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_OR  = 3'b010
    } alu_op_e;

endpackage

// File: rtl/rf_regfile.sv
// Module rf_regfile
// Register file with NRD combinational read ports and one write port.
// Entry 0 is hard-wired to zero: it is never written and always reads 0.
// Assumes write controls are stable around the rising clock edge.
module rf_regfile #(
    parameter int REG_CNT = 32,
    parameter int DATA_W  = 32,
    parameter int NRD     = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [$clog2(REG_CNT)-1:0]              wr_addr,
    input  logic [DATA_W-1:0]                       wr_data,
    input  logic [NRD-1:0][$clog2(REG_CNT)-1:0]     rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]              rd_data
);

    localparam int AW = $clog2(REG_CNT);

    logic [REG_CNT-1:0][DATA_W-1:0] regs;

    // Storage update: synchronous clear, then guarded writes skipping entry 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en && (wr_addr != AW'(0))) begin
            regs[wr_addr] <= wr_data;
        end
    end

    // One combinational read mux per port, entry 0 forced to zero
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == AW'(0)) begin
                rd_data[p] = '0;
            end else begin
                rd_data[p] = regs[rd_addr[p]];
            end
        end
    end

endmodule

// File: rtl/rf_imm_ext.sv
// Module rf_imm_ext
// Widens an IMM_W-bit immediate to DATA_W bits, either by zero fill
// or by replicating its top bit. Assumes DATA_W > IMM_W.
module rf_imm_ext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sext,
    output logic [DATA_W-1:0] wide
);

    localparam int PAD_W = DATA_W - IMM_W;

    // Choose the fill bit for the upper part and concatenate
    always_comb begin
        if (sext) begin
            wide = {{PAD_W{imm[IMM_W-1]}}, imm};
        end else begin
            wide = {{PAD_W{1'b0}}, imm};
        end
    end

endmodule

// File: rtl/rf_alu.sv
// Module rf_alu
// Combinational ALU: add, subtract (a - b) and OR, all modulo 2^DATA_W.
// Unassigned function codes yield zero. Flags an all-zero result.
module rf_alu
    import rf_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [ALU_OP_W-1:0] op,
    output logic [DATA_W-1:0]   res,
    output logic                zero
);

    // Function select
    always_comb begin
        case (op)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_OR:  res = opa | opb;
            default: res = '0;
        endcase
    end

    // Zero detect on the selected result
    always_comb begin
        zero = ~|res;
    end

endmodule

// File: rtl/rf_alu_datapath.sv
// Module rf_alu_datapath
// Execute and write-back datapath of a single-cycle load/store core:
// register file, immediate widener, ALU and the steering muxes.
// Assumes an external decoder drives all controls and holds them for a
// full clock period; data memory lives outside the block.
module rf_alu_datapath
    import rf_alu_pkg::*;
#(
    parameter int REG_CNT = 32,
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(REG_CNT)-1:0] rs_idx,
    input  logic [$clog2(REG_CNT)-1:0] rt_idx,
    input  logic [$clog2(REG_CNT)-1:0] rd_idx,
    input  logic [IMM_W-1:0]           imm_in,
    input  logic                       ctl_wr_en,
    input  logic                       ctl_dst_rd,
    input  logic                       ctl_use_imm,
    input  logic                       ctl_sext,
    input  logic                       ctl_load,
    input  logic [ALU_OP_W-1:0]        ctl_alu_op,
    input  logic [DATA_W-1:0]          ld_data,
    output logic [DATA_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          st_data,
    output logic                       alu_zero
);

    localparam int AW  = $clog2(REG_CNT);
    localparam int NRD = 2;
    localparam int PORT_A = 0;
    localparam int PORT_B = 1;

    logic [NRD-1:0][AW-1:0]     rd_addr;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic [AW-1:0]              wr_addr;
    logic [DATA_W-1:0]          wb_data;
    logic [DATA_W-1:0]          imm_wide;
    logic [DATA_W-1:0]          opb;
    logic [DATA_W-1:0]          alu_res;

    // Read-port index wiring
    always_comb begin
        rd_addr[PORT_A] = rs_idx;
        rd_addr[PORT_B] = rt_idx;
    end

    // Destination register select
    always_comb begin
        wr_addr = ctl_dst_rd ? rd_idx : rt_idx;
    end

    // Second ALU operand select
    always_comb begin
        opb = ctl_use_imm ? imm_wide : rd_data[PORT_B];
    end

    // Write-back source select
    always_comb begin
        wb_data = ctl_load ? ld_data : alu_res;
    end

    // Outputs toward data memory
    always_comb begin
        mem_addr = alu_res;
        st_data  = rd_data[PORT_B];
    end

    rf_regfile #(
        .REG_CNT (REG_CNT),
        .DATA_W  (DATA_W),
        .NRD     (NRD)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_addr (wr_addr),
        .wr_data (wb_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rf_imm_ext #(
        .IMM_W  (IMM_W),
        .DATA_W (DATA_W)
    ) u_ext (
        .imm  (imm_in),
        .sext (ctl_sext),
        .wide (imm_wide)
    );

    rf_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .opa  (rd_data[PORT_A]),
        .opb  (opb),
        .op   (ctl_alu_op),
        .res  (alu_res),
        .zero (alu_zero)
    );

endmodule

// File: rtl/rf_alu_datapath_chk.sv
// Module rf_alu_datapath_chk
// Property checker for rf_alu_datapath, attached by bind below.
// Assumes known control values from the first edge after reset.
module rf_alu_datapath_chk #(
    parameter int REG_CNT = 32,
    parameter int DATA_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(REG_CNT)-1:0] rt_idx,
    input logic                       ctl_wr_en,
    input logic                       ctl_dst_rd,
    input logic                       ctl_load,
    input logic [2:0]                 ctl_alu_op,
    input logic [DATA_W-1:0]          ld_data,
    input logic [DATA_W-1:0]          mem_addr,
    input logic [DATA_W-1:0]          st_data,
    input logic                       alu_zero
);

    AST_IDX0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_idx == '0) |-> (st_data == '0)); // R2

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en) |=> ($stable(rt_idx) -> $stable(st_data))); // R3

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_load && !ctl_dst_rd && (rt_idx != '0))
        |=> ($stable(rt_idx) -> (st_data == $past(ld_data)))); // R7

    AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_alu_op > 3'd2) |-> (mem_addr == '0)); // R8

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alu_zero == (mem_addr == '0)); // R9

endmodule

bind rf_alu_datapath rf_alu_datapath_chk #(
    .REG_CNT (REG_CNT),
    .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tb_rf_alu_datapath.sv
// Directed bench: inputs change on the falling edge, outputs are sampled
// 1 ns later, register writes land on the rising edge in between.
module tb_rf_alu_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rs_idx = '0, rt_idx = '0, rd_idx = '0;
    logic [15:0] imm_in = '0;
    logic        ctl_wr_en = 1'b0, ctl_dst_rd = 1'b0, ctl_use_imm = 1'b0;
    logic        ctl_sext = 1'b0, ctl_load = 1'b0;
    logic [2:0]  ctl_alu_op = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] mem_addr, st_data;
    logic        alu_zero;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [31:0] V1 = 32'h1234_5678;
    localparam logic [31:0] V2 = 32'h0F0F_0000;

    always #2.5 clk = ~clk;

    rf_alu_datapath dut (
        .clk(clk), .rst_n(rst_n), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .rd_idx(rd_idx), .imm_in(imm_in), .ctl_wr_en(ctl_wr_en),
        .ctl_dst_rd(ctl_dst_rd), .ctl_use_imm(ctl_use_imm),
        .ctl_sext(ctl_sext), .ctl_load(ctl_load), .ctl_alu_op(ctl_alu_op),
        .ld_data(ld_data), .mem_addr(mem_addr), .st_data(st_data),
        .alu_zero(alu_zero)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ctl_wr_en = 0; ctl_dst_rd = 0; ctl_use_imm = 0;
        ctl_sext = 0; ctl_load = 0; ctl_alu_op = 3'b000;
    endtask

    // Load a full 32-bit value through the memory write-back path
    task automatic load_reg(input logic [4:0] idx, input logic [31:0] val);
        @(negedge clk);
        idle();
        ctl_wr_en = 1; ctl_load = 1; rt_idx = idx; ld_data = val;
        @(posedge clk);
        #1;
        ctl_wr_en = 0;
    endtask

    // Read a register through rt_idx / st_data
    task automatic read_reg(input logic [4:0] idx, output logic [31:0] val);
        @(negedge clk);
        idle();
        rt_idx = idx;
        #1;
        val = st_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        load_reg(5'd5, 32'hCAFE_F00D);
        read_reg(5'd5, v);
        check("R3 value present before reset", v, 32'hCAFE_F00D);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        read_reg(5'd5, v);
        check("R1 reg5 cleared by reset", v, 32'h0);
        read_reg(5'd31, v);
        check("R1 reg31 reads zero", v, 32'h0);
    endtask

    task automatic t_reg0();
        logic [31:0] v;
        load_reg(5'd0, 32'hDEAD_BEEF);
        read_reg(5'd0, v);
        check("R2 reg0 ignores write (rt port)", v, 32'h0);
        @(negedge clk);
        idle(); rs_idx = 0; ctl_use_imm = 1; imm_in = 16'h0;
        #1;
        check("R2 reg0 reads zero on rs port", mem_addr, 32'h0);
    endtask

    task automatic t_write_enable();
        logic [31:0] v;
        load_reg(5'd3, 32'hAAAA_5555);
        read_reg(5'd3, v);
        check("R3 write visible after edge", v, 32'hAAAA_5555);
        @(negedge clk);
        idle(); ctl_load = 1; rt_idx = 3; ld_data = 32'h1111_2222;
        @(posedge clk); #1;
        read_reg(5'd3, v);
        check("R3 disabled write leaves value", v, 32'hAAAA_5555);
    endtask

    task automatic t_dst_select();
        logic [31:0] v;
        load_reg(5'd8, 32'h0000_0808);
        @(negedge clk);
        idle(); ctl_wr_en = 1; ctl_load = 1; ctl_dst_rd = 1;
        rt_idx = 8; rd_idx = 7; ld_data = 32'h7777_0007;
        @(posedge clk); #1;
        read_reg(5'd7, v);
        check("R4 rd chosen as destination", v, 32'h7777_0007);
        read_reg(5'd8, v);
        check("R4 rt untouched when rd chosen", v, 32'h0000_0808);
    endtask

    task automatic t_alu_reg();
        load_reg(5'd1, V1);
        load_reg(5'd2, V2);
        @(negedge clk);
        idle(); rs_idx = 1; rt_idx = 2; imm_in = 16'hFFFF;
        ctl_alu_op = 3'b000; #1;
        check("R8 add reg operands", mem_addr, 32'h2143_5678);
        check("R5 register operand ignores imm", mem_addr, V1 + V2);
        ctl_alu_op = 3'b001; #1;
        check("R8 subtract", mem_addr, 32'h0325_5678);
        ctl_alu_op = 3'b010; #1;
        check("R8 or", mem_addr, 32'h1F3F_5678);
        for (int c = 3; c < 8; c++) begin
            ctl_alu_op = 3'(c); #1;
            check("R8 unused code gives zero", mem_addr, 32'h0);
            check("R9 zero flag on unused code", {31'b0, alu_zero}, 32'h1);
        end
    endtask

    task automatic t_imm();
        @(negedge clk);
        idle(); rs_idx = 1; rt_idx = 2; ctl_use_imm = 1; imm_in = 16'h8001;
        ctl_sext = 1; ctl_alu_op = 3'b000; #1;
        check("R6 sign-extended add", mem_addr, 32'h1233_D679);
        ctl_sext = 0; #1;
        check("R6 zero-extended add", mem_addr, 32'h1234_D679);
        ctl_sext = 1; ctl_alu_op = 3'b010; #1;
        check("R5 imm operand OR sign-extended", mem_addr, 32'hFFFF_D679);
        check("R10 store data is rt while imm used", st_data, V2);
    endtask

    task automatic t_writeback_alu();
        logic [31:0] v;
        @(negedge clk);
        idle(); rs_idx = 1; rt_idx = 2; rd_idx = 9; ctl_dst_rd = 1;
        ctl_wr_en = 1; ctl_load = 0; ld_data = 32'hFFFF_FFFF; ctl_alu_op = 3'b000;
        @(posedge clk); #1;
        read_reg(5'd9, v);
        check("R7 ALU result written back", v, 32'h2143_5678);
    endtask

    task automatic t_zero();
        @(negedge clk);
        idle(); rs_idx = 1; rt_idx = 1; ctl_alu_op = 3'b001; #1;
        check("R9 equal regs raise zero", {31'b0, alu_zero}, 32'h1);
        check("R10 address carries result", mem_addr, 32'h0);
        rt_idx = 2; #1;
        check("R9 unequal regs clear zero", {31'b0, alu_zero}, 32'h0);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_reg0();
        t_write_enable();
        t_dst_select();
        t_alu_reg();
        t_imm();
        t_writeback_alu();
        t_zero();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule